// File: doc/BRIEF.md
# USB Low/Full-Speed Receive Assist

This block takes over the bit-level receive work of a software USB driver. It watches the differential line pair, finds the start of a packet and samples each bit near its middle at either the low-speed or the full-speed rate. Each sample is NRZI-decoded, stuffed bits are removed, and the surviving bits are packed least significant bit first into 32-bit entries. The processor collects these entries through a valid/ready handshake. Every bit the receiver keeps is delivered, including the sync pattern.

When a single-ended zero appears, the packet ends. Any partial word is flushed as a final entry that carries its bit count and an end marker. A turnaround timer then starts counting bit times, so the driver can tell whether it has missed the response deadline. A CRC16 register runs over the delivered bits after the sync and packet-identifier bits, and the driver reads it to check the packet.

Bit timing comes from a fixed count of system clocks per bit, with no edge tracking. Both divider values are expected to be even and at least 4. The line inputs are expected to be synchronous to `clk` already.

Top module: `usbrx_assist`

## Requirements
- R1: The idle level J is line_dp=1/line_dm=0 when speed_ls=0 and line_dp=0/line_dm=1 when speed_ls=1. A packet starts on the first non-SE0 cycle in which line_dp differs from J. The line must have returned to J after reset or after an end of packet before a new start is recognised.
- R2: Each bit is sampled once near its middle. A sample at the same level as the previous one (J for the first bit) decodes to 1, and a changed level decodes to 0.
- R3: After six consecutive delivered 1s, the next decoded bit is discarded and the run count restarts.
- R4: If a discarded bit decodes to 1, stuff_err goes high and stays high until the next packet start.
- R5: Delivered bits fill an entry from bit 0 upward. When 32 bits are collected, an entry with word_bits=32 and word_last=0 is produced.
- R6: A sample that finds both lines low ends the packet. It produces one entry with word_last=1 and word_bits equal to the remaining bit count (0 to 31), and the unused data bits in that entry are zero.
- R7: One bit period is FS_DIV clock cycles when speed_ls=0 and LS_DIV cycles when speed_ls=1.
- R8: A 2-entry buffer drives word_valid while it is not empty. An entry is removed on a cycle with word_valid and word_ready both high. While it waits, the entry stays stable.
- R9: An entry produced while the buffer is full, with no removal in the same cycle, is discarded. This sets overrun, which stays high until the next packet start. A removal in the same cycle lets the new entry in.
- R10: resp_late rises 7 bit periods of clock cycles after the end-of-packet sample, unless resp_start is pulsed first. It is cleared at the next packet start.
- R11: crc16 is set to 16'hFFFF at packet start and ignores the first 16 delivered bits. Each later bit b then updates it as fb=crc[15]^b, crc={crc[14:0],0}^(fb?16'h8005:0).
- R12: After reset, word_valid, stuff_err, overrun and resp_late are 0, and crc16 is 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_ls | input | 1 | 1 selects low speed, 0 selects full speed |
| line_dp | input | 1 | Positive line of the pair, synchronous to clk |
| line_dm | input | 1 | Negative line of the pair, synchronous to clk |
| word_ready | input | 1 | Processor accepts the presented entry |
| resp_start | input | 1 | Pulse: the driver has started its response |
| word_valid | output | 1 | An entry is presented |
| word_data | output | 32 | Received bits, first bit in bit 0 |
| word_bits | output | 6 | Number of valid bits in word_data |
| word_last | output | 1 | Entry closes the packet |
| stuff_err | output | 1 | A stuffed position held a 1 |
| overrun | output | 1 | An entry was lost to a full buffer |
| resp_late | output | 1 | Turnaround deadline passed |
| crc16 | output | 16 | Running CRC over the payload bits |

## Verification
Two events can meet at the buffer in the same cycle: a new entry arriving while both slots are full, and the processor removing the oldest entry. The bench holds word_ready low until two full words fill the buffer. It then raises word_ready for exactly the one clock edge where the end-of-packet sample lands. That edge is worked out from the bit period and the half-period sampling phase. The run passes only if overrun stays low and the three entries come out in their original order. A second run without that pulse must show overrun and lose the final entry.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;

  typedef enum logic [1:0] {
    LN_SETTLE = 2'd0,
    LN_IDLE   = 2'd1,
    LN_RUN    = 2'd2
  } line_state_e;

  // Level equal to the previous one means a 1, a change means a 0.
  function automatic logic nrzi_decode(input logic level_now, input logic level_before);
    return level_now == level_before;
  endfunction

  // One serial step of the CRC16 with generator 0x8005, feedback from bit 15.
  function automatic logic [15:0] crc16_shift(input logic [15:0] crc, input logic din);
    logic fb;
    fb = crc[15] ^ din;
    return {crc[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0000);
  endfunction

endpackage

// File: rtl/usbrx_sampler.sv
module usbrx_sampler
  import usbrx_pkg::*;
#(
  parameter int FS_DIV = 4,
  parameter int LS_DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic speed_ls,
  input  logic dp,
  input  logic dm,
  output logic pkt_start,
  output logic bit_evt,
  output logic bit_val,
  output logic eop_evt
);
  localparam int DIV_W = $clog2(LS_DIV + 1);

  line_state_e      st_q;
  logic [DIV_W-1:0] phase_q;
  logic             prev_q;
  logic             se0, j_dp, at_j, due;
  logic [DIV_W-1:0] div_sel;

  assign se0     = !dp && !dm;
  assign j_dp    = !speed_ls;
  assign at_j    = (dp == j_dp) && (dm != j_dp);
  assign div_sel = speed_ls ? DIV_W'(LS_DIV) : DIV_W'(FS_DIV);

  assign pkt_start = (st_q == LN_IDLE) && !se0 && (dp != j_dp);
  assign due       = (st_q == LN_RUN) && (phase_q == '0);
  assign eop_evt   = due && se0;
  assign bit_evt   = due && !se0;
  assign bit_val   = nrzi_decode(dp, prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= LN_SETTLE;
      phase_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      case (st_q)
        LN_SETTLE: if (at_j) st_q <= LN_IDLE;
        LN_IDLE: if (pkt_start) begin
          st_q    <= LN_RUN;
          phase_q <= (div_sel >> 1) - 1'b1;
          prev_q  <= j_dp;
        end
        LN_RUN: if (due) begin
          phase_q <= div_sel - 1'b1;
          if (se0) st_q <= LN_SETTLE;
          else     prev_q <= dp;
        end else begin
          phase_q <= phase_q - 1'b1;
        end
        default: st_q <= LN_SETTLE;
      endcase
    end
  end

  AST_EOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    eop_evt |=> !bit_evt && !eop_evt); // R6
  AST_SAMPLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    bit_evt |=> !bit_evt && !eop_evt); // R7

endmodule

// File: rtl/usbrx_unstuff.sv
module usbrx_unstuff (
  input  logic clk,
  input  logic rst_n,
  input  logic pkt_start,
  input  logic bit_evt,
  input  logic bit_val,
  output logic del_evt,
  output logic del_bit,
  output logic stuff_err
);
  logic [2:0] ones_q;
  logic       err_q, stuffed;

  assign stuffed   = bit_evt && (ones_q == 3'd6);
  assign del_evt   = bit_evt && !stuffed;
  assign del_bit   = bit_val;
  assign stuff_err = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones_q <= '0;
      err_q  <= 1'b0;
    end else if (pkt_start) begin
      ones_q <= '0;
      err_q  <= 1'b0;
    end else if (bit_evt) begin
      if (stuffed) begin
        ones_q <= '0;
        if (bit_val) err_q <= 1'b1;
      end else begin
        ones_q <= bit_val ? ones_q + 3'd1 : 3'd0;
      end
    end
  end

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= 3'd6); // R3
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(bit_evt && bit_val)); // R4

endmodule

// File: rtl/usbrx_packer.sv
module usbrx_packer
  import usbrx_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int DEPTH    = 2,
  parameter int CRC_SKIP = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pkt_start,
  input  logic                         del_evt,
  input  logic                         del_bit,
  input  logic                         eop_evt,
  input  logic                         rd_ready,
  output logic                         rd_valid,
  output logic [WORD_W-1:0]            rd_data,
  output logic [$clog2(WORD_W+1)-1:0]  rd_bits,
  output logic                         rd_last,
  output logic                         overrun,
  output logic [15:0]                  crc
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam int SK_W  = $clog2(CRC_SKIP + 1);

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [WORD_W-1:0] acc_q, acc_nx;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] mem_data [DEPTH];
  logic [CNT_W-1:0]  mem_bits [DEPTH];
  logic              mem_last [DEPTH];
  logic [PTR_W-1:0]  wp_q, rp_q;
  logic [OCC_W-1:0]  occ_q;
  logic              word_full, push, pop, accept, full;
  logic [WORD_W-1:0] push_data;
  logic [CNT_W-1:0]  push_bits;
  logic              push_last;
  logic              ovr_q;
  logic [15:0]       crc_q;
  logic [SK_W-1:0]   skip_q;

  assign acc_nx    = acc_q | (WORD_W'(del_bit) << cnt_q);
  assign word_full = del_evt && (cnt_q == CNT_W'(WORD_W - 1));
  assign push      = word_full || eop_evt;
  assign push_data = word_full ? acc_nx : acc_q;
  assign push_bits = word_full ? CNT_W'(WORD_W) : cnt_q;
  assign push_last = !word_full;

  assign full     = (occ_q == OCC_W'(DEPTH));
  assign rd_valid = (occ_q != '0);
  assign pop      = rd_valid && rd_ready;
  assign accept   = push && (!full || pop);
  assign rd_data  = mem_data[rp_q];
  assign rd_bits  = mem_bits[rp_q];
  assign rd_last  = mem_last[rp_q];
  assign overrun  = ovr_q;
  assign crc      = crc_q;

  // Bit accumulator
  always_ff @(posedge clk) begin
    if (!rst_n || pkt_start || push) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (del_evt) begin
      acc_q <= acc_nx;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Entry storage
  always_ff @(posedge clk) begin
    if (accept) begin
      mem_data[wp_q] <= push_data;
      mem_bits[wp_q] <= push_bits;
      mem_last[wp_q] <= push_last;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      occ_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      if (accept) wp_q <= ptr_next(wp_q);
      if (pop)    rp_q <= ptr_next(rp_q);
      occ_q <= occ_q + OCC_W'(accept) - OCC_W'(pop);
      if (pkt_start)            ovr_q <= 1'b0;
      else if (push && !accept) ovr_q <= 1'b1;
    end
  end

  // Payload CRC
  always_ff @(posedge clk) begin
    if (!rst_n || pkt_start) begin
      crc_q  <= 16'hFFFF;
      skip_q <= '0;
    end else if (del_evt) begin
      if (skip_q != SK_W'(CRC_SKIP)) skip_q <= skip_q + 1'b1;
      else                           crc_q  <= crc16_shift(crc_q, del_bit);
    end
  end

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OCC_W'(DEPTH)); // R8
  AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data) && $stable(rd_bits)); // R8
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(push && full && !rd_ready)); // R9
  AST_FULL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_last |-> rd_bits == CNT_W'(WORD_W)); // R5

endmodule

// File: rtl/usbrx_turnaround.sv
module usbrx_turnaround #(
  parameter int FS_DIV    = 4,
  parameter int LS_DIV    = 32,
  parameter int TURN_BITS = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic speed_ls,
  input  logic pkt_start,
  input  logic eop_evt,
  input  logic resp_start,
  output logic late
);
  localparam int TMR_W = $clog2(TURN_BITS * LS_DIV + 1);

  logic [TMR_W-1:0] cnt_q, limit;
  logic             run_q, late_q;

  assign limit = speed_ls ? TMR_W'(TURN_BITS * LS_DIV) : TMR_W'(TURN_BITS * FS_DIV);
  assign late  = late_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      late_q <= 1'b0;
    end else if (pkt_start) begin
      run_q  <= 1'b0;
      late_q <= 1'b0;
    end else if (eop_evt) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q) begin
      if (resp_start) begin
        run_q <= 1'b0;
      end else if (cnt_q == limit - 1'b1) begin
        run_q  <= 1'b0;
        late_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_LATE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |=> !late_q); // R10
  AST_LATE_TIMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(late_q) |-> $past(run_q && !resp_start)); // R10

endmodule

// File: rtl/usbrx_assist.sv
module usbrx_assist #(
  parameter int FS_DIV    = 4,
  parameter int LS_DIV    = 32,
  parameter int WORD_W    = 32,
  parameter int DEPTH     = 2,
  parameter int CRC_SKIP  = 16,
  parameter int TURN_BITS = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        speed_ls,
  input  logic                        line_dp,
  input  logic                        line_dm,
  input  logic                        word_ready,
  input  logic                        resp_start,
  output logic                        word_valid,
  output logic [WORD_W-1:0]           word_data,
  output logic [$clog2(WORD_W+1)-1:0] word_bits,
  output logic                        word_last,
  output logic                        stuff_err,
  output logic                        overrun,
  output logic                        resp_late,
  output logic [15:0]                 crc16
);
  logic pkt_start, bit_evt, bit_val, eop_evt, del_evt, del_bit;

  usbrx_sampler #(.FS_DIV(FS_DIV), .LS_DIV(LS_DIV)) u_sampler (
    .clk(clk), .rst_n(rst_n), .speed_ls(speed_ls), .dp(line_dp), .dm(line_dm),
    .pkt_start(pkt_start), .bit_evt(bit_evt), .bit_val(bit_val), .eop_evt(eop_evt)
  );

  usbrx_unstuff u_unstuff (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .bit_evt(bit_evt),
    .bit_val(bit_val), .del_evt(del_evt), .del_bit(del_bit), .stuff_err(stuff_err)
  );

  usbrx_packer #(.WORD_W(WORD_W), .DEPTH(DEPTH), .CRC_SKIP(CRC_SKIP)) u_packer (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .del_evt(del_evt),
    .del_bit(del_bit), .eop_evt(eop_evt), .rd_ready(word_ready),
    .rd_valid(word_valid), .rd_data(word_data), .rd_bits(word_bits),
    .rd_last(word_last), .overrun(overrun), .crc(crc16)
  );

  usbrx_turnaround #(.FS_DIV(FS_DIV), .LS_DIV(LS_DIV), .TURN_BITS(TURN_BITS)) u_turn (
    .clk(clk), .rst_n(rst_n), .speed_ls(speed_ls), .pkt_start(pkt_start),
    .eop_evt(eop_evt), .resp_start(resp_start), .late(resp_late)
  );

  AST_START_FROM_J: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |-> !(line_dp == !speed_ls && line_dm == speed_ls)); // R1

endmodule

// File: tb/test_usbrx_assist.sv
module test_usbrx_assist;
  localparam int FS_DIV = 4;
  localparam int LS_DIV = 32;
  localparam int NV = 4;
  localparam logic [63:0] V_VAL [NV] = '{64'h0000_0000_0000_A580, 64'h0000_007E_FFC3_4B80,
                                        64'h0000_0000_005A_D280, 64'hFFFF_0123_4567_8980};
  localparam int   V_N  [NV] = '{16, 40, 24, 64};
  localparam logic V_LS [NV] = '{1'b0, 1'b0, 1'b1, 1'b0};

  logic clk = 1'b0, rst_n = 1'b0, speed_ls = 1'b0, line_dp = 1'b1, line_dm = 1'b0;
  logic word_ready = 1'b1, resp_start = 1'b0;
  logic word_valid, word_last, stuff_err, overrun, resp_late;
  logic [31:0] word_data;
  logic [5:0]  word_bits;
  logic [15:0] crc16;

  usbrx_assist #(.FS_DIV(FS_DIV), .LS_DIV(LS_DIV)) i_usbrx_assist (
    .clk(clk), .rst_n(rst_n), .speed_ls(speed_ls), .line_dp(line_dp), .line_dm(line_dm),
    .word_ready(word_ready), .resp_start(resp_start), .word_valid(word_valid),
    .word_data(word_data), .word_bits(word_bits), .word_last(word_last),
    .stuff_err(stuff_err), .overrun(overrun), .resp_late(resp_late), .crc16(crc16)
  );

  always #5 clk = ~clk;

  int n_run = 0, n_fail = 0;
  logic [31:0] got_data [8];
  logic [5:0]  got_bits [8];
  logic        got_last [8];
  int          got_n = 0;

  always @(negedge clk) begin
    #2;
    if (word_valid && word_ready && got_n < 8) begin
      got_data[got_n] = word_data;
      got_bits[got_n] = word_bits;
      got_last[got_n] = word_last;
      got_n++;
    end
  end

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic drive_lvl(input logic ls, input logic is_j);
    line_dp = is_j ^ ls;
    line_dm = !(is_j ^ ls);
  endtask

  task automatic send_pkt(input logic [63:0] val, input int n, input logic ls,
                          input logic stuff_on, input logic pulse_ready);
    logic enc [100];
    int ne, ones, div;
    logic lvl;
    ne = 0; ones = 0;
    div = ls ? LS_DIV : FS_DIV;
    for (int i = 0; i < n; i++) begin
      enc[ne] = val[i]; ne++;
      if (val[i]) ones++; else ones = 0;
      if (stuff_on && ones == 6) begin enc[ne] = 1'b0; ne++; ones = 0; end
    end
    @(negedge clk);
    speed_ls = ls;
    drive_lvl(ls, 1'b1);
    repeat (4 * div) @(negedge clk);
    lvl = 1'b1;
    for (int i = 0; i < ne; i++) begin
      if (!enc[i]) lvl = !lvl;
      drive_lvl(ls, lvl);
      repeat (div) @(negedge clk);
    end
    line_dp = 1'b0; line_dm = 1'b0;
    if (pulse_ready) begin
      repeat (div / 2) @(negedge clk);
      word_ready = 1'b1;
      @(negedge clk);
      word_ready = 1'b0;
      repeat (2 * div - div / 2 - 1) @(negedge clk);
    end else begin
      repeat (2 * div) @(negedge clk);
    end
    drive_lvl(ls, 1'b1);
    repeat (div) @(negedge clk);
  endtask

  function automatic logic [15:0] ref_crc(input logic [63:0] val, input int n);
    logic [15:0] r, o;
    r = 16'hFFFF;
    for (int i = 16; i < n; i++) r = (r[0] ^ val[i]) ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    for (int k = 0; k < 16; k++) o[k] = r[15 - k];
    return o;
  endfunction

  task automatic check_pkt(input logic [63:0] val, input int n, input string tag);
    int nw, rem;
    logic [31:0] exp_last;
    nw = n / 32; rem = n % 32;
    chk({tag, " R1 entry count"}, got_n, nw + 1);
    for (int w = 0; w < nw && w < got_n; w++) begin
      chk({tag, " R2 R3 word data"}, got_data[w], val[w*32 +: 32]);
      chk({tag, " R5 full bits"}, {26'd0, got_bits[w]}, 32);
      chk({tag, " R5 not last"}, {31'd0, got_last[w]}, 0);
    end
    exp_last = (rem == 0) ? 32'd0 : (val[nw*32 +: 32] & ((32'd1 << rem) - 1));
    if (got_n > nw) begin
      chk({tag, " R6 last data"}, got_data[nw], exp_last);
      chk({tag, " R6 last bits"}, {26'd0, got_bits[nw]}, rem);
      chk({tag, " R6 last flag"}, {31'd0, got_last[nw]}, 1);
    end
    chk({tag, " R11 crc"}, {16'd0, crc16}, {16'd0, ref_crc(val, n)});
    chk({tag, " R4 no stuff error"}, {31'd0, stuff_err}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // R12 reset state, R1 no start on idle line
    chk("R12 valid", {31'd0, word_valid}, 0);
    chk("R12 stuff_err", {31'd0, stuff_err}, 0);
    chk("R12 overrun", {31'd0, overrun}, 0);
    chk("R12 resp_late", {31'd0, resp_late}, 0);
    chk("R12 crc", {16'd0, crc16}, 32'hFFFF);
    chk("R1 idle gives no entry", got_n, 0);

    // Vector table; entry 2 is low speed (R7)
    for (int v = 0; v < NV; v++) begin
      got_n = 0;
      word_ready = 1'b1;
      send_pkt(V_VAL[v], V_N[v], V_LS[v], 1'b1, 1'b0);
      repeat (4) @(negedge clk);
      check_pkt(V_VAL[v], V_N[v], V_LS[v] ? "R7 low speed" : "full speed");
    end

    // R4 unstuffed run of ones
    got_n = 0;
    send_pkt(64'h0000_0000_0000_FF80, 16, 1'b0, 1'b0, 1'b0);
    chk("R4 stuff error set", {31'd0, stuff_err}, 1);
    got_n = 0;
    send_pkt(V_VAL[0], V_N[0], 1'b0, 1'b1, 1'b0);
    chk("R4 stuff error cleared", {31'd0, stuff_err}, 0);

    // R10 deadline: rises 7 bit periods after the end-of-packet sample
    repeat (FS_DIV / 2 + 4 * FS_DIV) @(negedge clk);
    chk("R10 not yet late", {31'd0, resp_late}, 0);
    @(negedge clk);
    chk("R10 late", {31'd0, resp_late}, 1);

    // R10 cleared at packet start, cancelled by resp_start
    send_pkt(V_VAL[0], V_N[0], 1'b0, 1'b1, 1'b0);
    chk("R10 cleared by start", {31'd0, resp_late}, 0);
    resp_start = 1'b1;
    @(negedge clk);
    resp_start = 1'b0;
    repeat (10 * FS_DIV) @(negedge clk);
    chk("R10 cancelled", {31'd0, resp_late}, 0);

    // R9 overrun with no reader, R8 hold
    got_n = 0;
    word_ready = 1'b0;
    send_pkt(V_VAL[3], 64, 1'b0, 1'b1, 1'b0);
    chk("R9 overrun set", {31'd0, overrun}, 1);
    chk("R8 valid held", {31'd0, word_valid}, 1);
    chk("R8 oldest presented", word_data, V_VAL[3][31:0]);
    repeat (5) @(negedge clk);
    chk("R8 entry stable", word_data, V_VAL[3][31:0]);
    word_ready = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 lost entry", got_n, 2);
    chk("R9 second kept", got_data[1], V_VAL[3][63:32]);

    // R9 push into full buffer with a pop in the same cycle
    got_n = 0;
    word_ready = 1'b0;
    send_pkt(V_VAL[3], 64, 1'b0, 1'b1, 1'b1);
    chk("R9 no overrun when popped", {31'd0, overrun}, 0);
    word_ready = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 all entries kept", got_n, 3);
    chk("R9 order word0", got_data[0], V_VAL[3][31:0]);
    chk("R9 order word1", got_data[1], V_VAL[3][63:32]);
    chk("R9 closing entry", {31'd0, got_last[2]}, 1);
    chk("R9 closing bits", {26'd0, got_bits[2]}, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule